// File: doc/BRIEF.md
# Converter Host Bus Control and Output Formatter

This block sits between a microprocessor bus and a 12-bit successive-approximation conversion sequencer. It decodes five host control inputs: an active-high enable, an active-low select, a read/convert line, a word-format select and a byte selector. From these it raises a one-cycle start request toward the sequencer, with a flag that asks for a short 8-bit cycle. On reads it presents the sequencer's result on a 12-bit output bus. The bus is split into three 4-bit lanes, and each lane has its own enable that stands in for a three-state buffer.

A 16-bit host reads the whole result in one access. An 8-bit host reads it in two accesses. The upper access returns the top eight bits. The lower access returns the bottom four bits on the low lane, drives zeros on the middle lane and leaves the top lane off. The second byte therefore reads left-justified, with trailing zeros.

The same decode also serves standalone use, where enable and word-format are tied high and select and byte selector are tied low. In that use the read/convert line alone controls the part: while it is high the outputs are on, and its falling edge starts a conversion. While the sequencer is busy the outputs stay off, except inside a configurable window of remaining cycles at the end of the conversion.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, `conv_start` is 0, all three lane enables are 0 and `dout` is 0.
- R2: While `en` is 0 or `sel_n` is 1, no start request is issued and all lane enables stay 0, whatever the other control inputs are.
- R3: A start is requested when the convert command (`en`=1, `sel_n`=0, `rd_cnv`=0) first becomes true while the sequencer is idle. `conv_start` pulses high on the clock edge after the command is first sampled. `conv_short` then equals the `byte_sel` value sampled with it: 0 asks for the 12-bit cycle and 1 asks for the 8-bit cycle.
- R4: A convert command held over many cycles gives exactly one start pulse.
- R5: A convert command that appears while `seq_busy` is 1 gives no start pulse.
- R6: A read (`en`=1, `sel_n`=0, `rd_cnv`=1) with `word_mode`=1 enables all three lanes and drives `dout` = `seq_result`, one clock after sampling.
- R7: A read with `word_mode`=0 and `byte_sel`=0 enables the top lane (bits 11:8) and the middle lane (bits 7:4) with `seq_result[11:4]`, and disables the low lane (bits 3:0).
- R8: A read with `word_mode`=0 and `byte_sel`=1 drives `seq_result[3:0]` on the enabled low lane and zeros on the enabled middle lane, and disables the top lane.
- R9: While `seq_busy` is 1, reads enable no lane unless `seq_left` is at most `EARLY_WIN` (default 2). A lane that is disabled drives 0 on `dout`.
- R10: In standalone use, the falling edge of `rd_cnv` requests a start and turns the outputs off. After the sequencer goes idle with `rd_cnv` high again, the outputs come back on with the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Access enable, active high |
| sel_n | input | 1 | Device select, active low |
| rd_cnv | input | 1 | 1 = read, 0 = convert |
| word_mode | input | 1 | 1 = one 12-bit word, 0 = two bytes |
| byte_sel | input | 1 | Byte selector on reads; short-cycle request on converts |
| seq_busy | input | 1 | Sequencer conversion in progress |
| seq_left | input | LEFT_W | Cycles remaining in the current conversion |
| seq_result | input | 3*NIB_W | Latest conversion result |
| conv_start | output | 1 | One-cycle start request |
| conv_short | output | 1 | Short-cycle flag belonging to the last start |
| dout | output | 3*NIB_W | Output data bus |
| oe_hi | output | 1 | Top lane enable |
| oe_mid | output | 1 | Middle lane enable |
| oe_lo | output | 1 | Low lane enable |

## Verification
The hardest condition to reach from the ports is a read that arrives while the sequencer is busy, with the remaining count on either side of the early window. It is also hard to follow a standalone low pulse through busy and back to idle. The bench drives the sequencer-side inputs directly. It can therefore hold busy high and step the remaining count across every value around the window. It can also replay a standalone pulse in which the read line returns high well before the conversion ends.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
    localparam int LANES = 3;

    typedef enum logic [1:0] {
        FMT_WORD  = 2'd0,
        FMT_UPPER = 2'd1,
        FMT_LOWER = 2'd2
    } rd_fmt_e;
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
    import adc_bus_pkg::*;
#(
    parameter int LEFT_W    = 4,
    parameter int EARLY_WIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sel_n,
    input  logic              rd_cnv,
    input  logic              word_mode,
    input  logic              byte_sel,
    input  logic              busy,
    input  logic [LEFT_W-1:0] left,
    output logic              start,
    output logic              shrt,
    output logic              rd_go,
    output rd_fmt_e           fmt
);
    localparam logic [LEFT_W-1:0] WIN_V = LEFT_W'(EARLY_WIN);

    typedef struct packed {
        logic cmd_prev;
        logic start;
        logic shrt;
    } dec_t;

    dec_t dec_d, dec_q;
    logic cmd, access, out_ok;

    always_comb begin
        access = en & ~sel_n;
        cmd    = access & ~rd_cnv;
        out_ok = ~busy | (left <= WIN_V);
        dec_d          = dec_q;
        dec_d.cmd_prev = cmd;
        dec_d.start    = cmd & ~dec_q.cmd_prev & ~busy;
        if (dec_d.start) dec_d.shrt = byte_sel;
        rd_go = access & rd_cnv & out_ok;
        if (word_mode)     fmt = FMT_WORD;
        else if (byte_sel) fmt = FMT_LOWER;
        else               fmt = FMT_UPPER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign start = dec_q.start;
    assign shrt  = dec_q.shrt;

    // R4: a start pulse lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R5: no start while the sequencer was busy
    a_r5_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(!busy));
    // R3: short flag follows the sampled byte selector
    a_r3_short_flag: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (shrt == $past(byte_sel)));
endmodule

// File: rtl/adc_out_format.sv
module adc_out_format
    import adc_bus_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_go,
    input  rd_fmt_e              fmt,
    input  logic [LANES*NIB_W-1:0] result,
    output logic [LANES*NIB_W-1:0] dout,
    output logic [LANES-1:0]       oe
);
    localparam int DW = LANES * NIB_W;

    typedef struct packed {
        logic [DW-1:0]    data;
        logic [LANES-1:0] oe;
    } fmt_t;

    fmt_t fmt_d, fmt_q;
    logic [DW-1:0]    lane_val;
    logic [LANES-1:0] lane_on;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_on[g] = 1'b0;
            lane_val[g*NIB_W +: NIB_W] = '0;
            unique case (fmt)
                FMT_WORD: begin
                    lane_on[g] = 1'b1;
                    lane_val[g*NIB_W +: NIB_W] = result[g*NIB_W +: NIB_W];
                end
                FMT_UPPER: begin
                    lane_on[g] = (g != 0);
                    if (g != 0)
                        lane_val[g*NIB_W +: NIB_W] = result[g*NIB_W +: NIB_W];
                end
                FMT_LOWER: begin
                    lane_on[g] = (g != LANES - 1);
                    if (g == 0)
                        lane_val[g*NIB_W +: NIB_W] = result[g*NIB_W +: NIB_W];
                end
                default: lane_on[g] = 1'b0;
            endcase
        end
    end

    always_comb begin
        fmt_d      = '0;
        if (rd_go) begin
            fmt_d.oe   = lane_on;
            fmt_d.data = lane_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fmt_q <= '0;
        else        fmt_q <= fmt_d;
    end

    assign dout = fmt_q.data;
    assign oe   = fmt_q.oe;

    // R8: middle lane on with top lane off carries zero fill
    a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (oe[1] && !oe[2]) |-> (dout[2*NIB_W-1:NIB_W] == '0));
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int LEFT_W    = 4,
    parameter int EARLY_WIN = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   sel_n,
    input  logic                   rd_cnv,
    input  logic                   word_mode,
    input  logic                   byte_sel,
    input  logic                   seq_busy,
    input  logic [LEFT_W-1:0]      seq_left,
    input  logic [3*NIB_W-1:0]     seq_result,
    output logic                   conv_start,
    output logic                   conv_short,
    output logic [3*NIB_W-1:0]     dout,
    output logic                   oe_hi,
    output logic                   oe_mid,
    output logic                   oe_lo
);
    localparam logic [LEFT_W-1:0] WIN_V = LEFT_W'(EARLY_WIN);

    logic             rd_go;
    rd_fmt_e          fmt;
    logic [LANES-1:0] oe;

    adc_cmd_decode #(.LEFT_W(LEFT_W), .EARLY_WIN(EARLY_WIN)) u_dec (
        .clk(clk), .rst_n(rst_n), .en(en), .sel_n(sel_n), .rd_cnv(rd_cnv),
        .word_mode(word_mode), .byte_sel(byte_sel), .busy(seq_busy),
        .left(seq_left), .start(conv_start), .shrt(conv_short),
        .rd_go(rd_go), .fmt(fmt)
    );

    adc_out_format #(.NIB_W(NIB_W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .fmt(fmt),
        .result(seq_result), .dout(dout), .oe(oe)
    );

    assign oe_hi  = oe[2];
    assign oe_mid = oe[1];
    assign oe_lo  = oe[0];

    // R2: any lane enable needs a selected read on the previous edge
    a_r2_selected_read: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hi || oe_mid || oe_lo) |-> $past(en && !sel_n && rd_cnv));
    // R9: outputs are off while busy outside the early window
    a_r9_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hi || oe_mid || oe_lo) |-> $past(!seq_busy || (seq_left <= WIN_V)));
    // R2: a start also needs the device selected
    a_r2_start_selected: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(en && !sel_n && !rd_cnv));
endmodule

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, sel_n = 1'b1, rd_cnv = 1'b1, word_mode = 1'b1, byte_sel = 1'b0;
    logic        seq_busy = 1'b0;
    logic [3:0]  seq_left = '0;
    logic [11:0] seq_result = '0;
    logic        conv_start, conv_short, oe_hi, oe_mid, oe_lo;
    logic [11:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_bus_ctrl u_adc_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .sel_n(sel_n), .rd_cnv(rd_cnv),
        .word_mode(word_mode), .byte_sel(byte_sel), .seq_busy(seq_busy),
        .seq_left(seq_left), .seq_result(seq_result), .conv_start(conv_start),
        .conv_short(conv_short), .dout(dout), .oe_hi(oe_hi), .oe_mid(oe_mid),
        .oe_lo(oe_lo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [2:0] exp_oe(input logic w, input logic b);
        if (w) return 3'b111;
        return b ? 3'b011 : 3'b110;
    endfunction

    function automatic logic [11:0] exp_data(input logic [11:0] r, input logic w, input logic b);
        if (w) return r;
        return b ? {8'h00, r[3:0]} : {r[11:4], 4'h0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 start", conv_start, 0);
        chk("R1 oe", {oe_hi, oe_mid, oe_lo}, 0);
        chk("R1 dout", dout, 0);
        rst_n = 1'b1;
        tick();

        // R2: every non-selected combination
        seq_result = 12'hABC;
        for (int e = 0; e < 2; e++)
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 8; k++) begin
                    if (e == 1 && s == 0) continue;
                    en = e[0]; sel_n = s[0];
                    rd_cnv = k[0]; word_mode = k[1]; byte_sel = k[2];
                    tick();
                    chk("R2 start", conv_start, 0);
                    chk("R2 oe", {oe_hi, oe_mid, oe_lo}, 0);
                    chk("R2 dout", dout, 0);
                end

        // R6 R7 R8: read format sweep
        en = 1'b1; sel_n = 1'b0; rd_cnv = 1'b1;
        for (int v = 0; v < 16; v++)
            for (int m = 0; m < 4; m++) begin
                logic [11:0] r;
                r = 12'((v * 12'h9E3 + 12'h015) & 12'hFFF);
                seq_result = r; word_mode = m[1]; byte_sel = m[0];
                tick();
                if (m[1]) begin
                    chk("R6 oe", {oe_hi, oe_mid, oe_lo}, exp_oe(1'b1, m[0]));
                    chk("R6 dout", dout, exp_data(r, 1'b1, m[0]));
                end else if (!m[0]) begin
                    chk("R7 oe", {oe_hi, oe_mid, oe_lo}, exp_oe(1'b0, 1'b0));
                    chk("R7 dout", dout, exp_data(r, 1'b0, 1'b0));
                end else begin
                    chk("R8 oe", {oe_hi, oe_mid, oe_lo}, exp_oe(1'b0, 1'b1));
                    chk("R8 dout", dout, exp_data(r, 1'b0, 1'b1));
                end
            end

        // R9: busy window sweep
        word_mode = 1'b1; byte_sel = 1'b0; seq_result = 12'h5A3; seq_busy = 1'b1;
        for (int l = 0; l < 8; l++) begin
            seq_left = 4'(l);
            tick();
            chk("R9 oe", {oe_hi, oe_mid, oe_lo}, (l <= 2) ? 3'b111 : 3'b000);
            chk("R9 dout", dout, (l <= 2) ? 12'h5A3 : 12'h000);
        end
        seq_busy = 1'b0; seq_left = '0;

        // R3 R4: single start with short flag
        for (int b = 0; b < 2; b++) begin
            rd_cnv = 1'b1; tick();
            rd_cnv = 1'b0; byte_sel = b[0];
            tick();
            chk("R3 start", conv_start, 1);
            chk("R3 short", conv_short, b);
            tick();
            chk("R4 held", conv_start, 0);
            tick();
            chk("R4 held2", conv_start, 0);
            chk("R3 short kept", conv_short, b);
        end

        // R5: start ignored while busy
        rd_cnv = 1'b1; byte_sel = 1'b0; tick();
        seq_busy = 1'b1; seq_left = 4'd9;
        rd_cnv = 1'b0; tick();
        chk("R5 no start", conv_start, 0);
        tick();
        chk("R5 no start2", conv_start, 0);
        rd_cnv = 1'b1; seq_busy = 1'b0; seq_left = '0; tick();

        // R10: standalone low pulse
        en = 1'b1; sel_n = 1'b0; word_mode = 1'b1; byte_sel = 1'b0;
        seq_result = 12'h3C7; rd_cnv = 1'b1; tick();
        chk("R10 on before", {oe_hi, oe_mid, oe_lo}, 3'b111);
        rd_cnv = 1'b0; tick();
        chk("R10 start", conv_start, 1);
        chk("R10 off", {oe_hi, oe_mid, oe_lo}, 3'b000);
        seq_busy = 1'b1; seq_left = 4'd6; rd_cnv = 1'b1; tick();
        chk("R10 busy off", {oe_hi, oe_mid, oe_lo}, 3'b000);
        chk("R10 one start", conv_start, 0);
        seq_left = 4'd4; tick();
        chk("R10 still off", {oe_hi, oe_mid, oe_lo}, 3'b000);
        seq_busy = 1'b0; seq_left = '0; seq_result = 12'hE81; tick();
        chk("R10 back on", {oe_hi, oe_mid, oe_lo}, 3'b111);
        chk("R10 data", dout, 12'hE81);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule